// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits on the transmit side of a 10 Mb/s Ethernet port and watches the internal transmit-request level. A normal frame raises the request for a bounded time and then drops it. If one request stays high for longer than a configured limit, the block cuts the transmitter off by forcing its gated transmit-enable low. It raises a status flag and, in the first cycle of the lockout, a one-cycle event pulse.

The lockout does not end at a fixed time after entry. It ends only after a recovery interval measured from the moment the request goes away. If the request comes back during that interval, the recovery count is discarded and starts again once the request drops. Both limits are parameters counted in ticks of a one-microsecond strobe. The defaults (105 000 and 406 000 ticks) give about 105 ms and 406 ms, and a bench can use small values.

The controller has three named states. ST_RUN (code 2'b00) is normal operation: the request passes through. ST_HELD (2'b01) is the lockout while the request is still high. ST_RECOVER (2'b10) is the lockout while the request is low and the recovery timer counts. The transitions are:
- RUN_TO_HELD: on the strobe tick that completes the active limit.
- HELD_TO_RECOVER: when the request drops.
- RECOVER_TO_HELD: when the request reasserts.
- RECOVER_TO_RUN: on the strobe tick that completes the recovery limit.

Top module: `jab_watchdog`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the following cycle shows `jab_state` = 2'b00 (ST_RUN), `jab_active` = 0 and `jab_start` = 0.
- R2: In ST_RUN, `tx_en` equals `tx_req` in the same cycle.
- R3: In ST_RUN, the controller moves to ST_HELD (2'b01) at the clock edge where `tick` and `tx_req` are both high and this is the JAB_TICKS-th tick seen while `tx_req` has stayed high. From that cycle on, `jab_active` = 1 and `tx_en` = 0.
- R4: Any cycle in ST_RUN with `tx_req` low clears the active-duration count. A new request needs a full JAB_TICKS ticks to reach the lockout, and the count never reaches JAB_TICKS.
- R5: `jab_start` is high for exactly one cycle, the first cycle of ST_HELD entered from ST_RUN. It stays low when ST_HELD is re-entered from ST_RECOVER.
- R6: In ST_HELD and ST_RECOVER, `tx_en` is 0 whatever `tx_req` is. ST_HELD lasts as long as `tx_req` stays high, however many ticks pass.
- R7: In ST_HELD, a cycle with `tx_req` low moves the controller to ST_RECOVER (2'b10) at the next edge. A tick in that cycle is not counted toward recovery.
- R8: In ST_RECOVER with `tx_req` low, the controller returns to ST_RUN at the edge of the UNJAB_TICKS-th tick counted in ST_RECOVER. Cycles without a tick do not advance the count, and the count never reaches UNJAB_TICKS.
- R9: In ST_RECOVER, a cycle with `tx_req` high moves the controller back to ST_HELD at the next edge. After the next drop, recovery again needs a full UNJAB_TICKS ticks.
- R10: Neither timer advances in a cycle with `tick` low. Even a request held high for many cycles without ticks leaves the controller in ST_RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe, nominally once per microsecond |
| tx_req | input | 1 | Internal transmit-request level |
| tx_en | output | 1 | Gated transmit-enable |
| jab_active | output | 1 | High while in either lockout state |
| jab_start | output | 1 | One-cycle pulse when a lockout begins |
| jab_state | output | 2 | Controller state: 00 run, 01 held, 10 recover |

## Verification
The assertions check the following on every cycle:
- Transmit-enable follows the request in ST_RUN and is forced low in both lockout states.
- The event pulse lasts one cycle and appears only on entry from ST_RUN.
- The request edges move the controller between ST_HELD and ST_RECOVER.
- The lockout is entered only on a tick with the request high, and neither counter reaches its limit.

Only the bench scenarios can show the exact tick on which the lockout begins and ends, that a short gap clears the active count, and that a reassertion during recovery restarts the full interval. These depend on counts over many cycles rather than on one step.

// File: rtl/jab_pkg.sv
package jab_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_HELD    = 2'b01,
        ST_RECOVER = 2'b10
    } jab_state_e;

    // Bits needed to hold values 0 .. limit-1
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/jab_tick_counter.sv
module jab_tick_counter #(
    parameter int LIMIT = 16,
    localparam int CW = jab_pkg::cnt_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic          hit,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    // hit marks the increment that would complete LIMIT ticks
    assign hit = inc && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            if (hit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/jab_fsm.sv
module jab_fsm
    import jab_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       tx_req,
    input  logic       act_hit,
    input  logic       rec_hit,
    output jab_state_e state,
    output logic       act_clr,
    output logic       act_inc,
    output logic       rec_clr,
    output logic       rec_inc,
    output logic       tx_en,
    output logic       jab_active,
    output logic       jab_start
);

    jab_state_e state_nx;
    logic       start_nx;

    // Next-state decision
    always_comb begin
        state_nx = state;
        start_nx = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (act_hit) begin
                    state_nx = ST_HELD;        // RUN_TO_HELD
                    start_nx = 1'b1;
                end
            end
            ST_HELD: begin
                if (!tx_req) begin
                    state_nx = ST_RECOVER;     // HELD_TO_RECOVER
                end
            end
            ST_RECOVER: begin
                if (tx_req) begin
                    state_nx = ST_HELD;        // RECOVER_TO_HELD
                end else if (rec_hit) begin
                    state_nx = ST_RUN;         // RECOVER_TO_RUN
                end
            end
            default: begin
                state_nx = ST_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            jab_start <= 1'b0;
        end else begin
            state     <= state_nx;
            jab_start <= start_nx;
        end
    end

    // Outputs and timer controls
    always_comb begin
        tx_en      = 1'b0;
        jab_active = 1'b1;
        act_clr    = 1'b1;
        act_inc    = 1'b0;
        rec_clr    = 1'b1;
        rec_inc    = 1'b0;
        unique case (state)
            ST_RUN: begin
                tx_en      = tx_req;
                jab_active = 1'b0;
                act_clr    = !tx_req;
                act_inc    = tx_req && tick;
            end
            ST_HELD: begin
                tx_en = 1'b0;
            end
            ST_RECOVER: begin
                rec_clr = tx_req;
                rec_inc = !tx_req && tick;
            end
            default: begin
                tx_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/jab_watchdog.sv
module jab_watchdog #(
    parameter int JAB_TICKS   = 105000,
    parameter int UNJAB_TICKS = 406000,
    localparam int ACW = jab_pkg::cnt_width(JAB_TICKS),
    localparam int RCW = jab_pkg::cnt_width(UNJAB_TICKS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       tx_req,
    output logic       tx_en,
    output logic       jab_active,
    output logic       jab_start,
    output logic [1:0] jab_state
);

    import jab_pkg::*;

    jab_state_e         fsm_state;
    logic               act_clr;
    logic               act_inc;
    logic               act_hit;
    logic               rec_clr;
    logic               rec_inc;
    logic               rec_hit;
    logic [ACW-1:0]     act_cnt;
    logic [RCW-1:0]     rec_cnt;

    jab_tick_counter #(.LIMIT(JAB_TICKS)) act_tmr_i (
        .clk (clk),
        .rst (rst),
        .clr (act_clr),
        .inc (act_inc),
        .hit (act_hit),
        .cnt (act_cnt)
    );

    jab_tick_counter #(.LIMIT(UNJAB_TICKS)) rec_tmr_i (
        .clk (clk),
        .rst (rst),
        .clr (rec_clr),
        .inc (rec_inc),
        .hit (rec_hit),
        .cnt (rec_cnt)
    );

    jab_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .tx_req     (tx_req),
        .act_hit    (act_hit),
        .rec_hit    (rec_hit),
        .state      (fsm_state),
        .act_clr    (act_clr),
        .act_inc    (act_inc),
        .rec_clr    (rec_clr),
        .rec_inc    (rec_inc),
        .tx_en      (tx_en),
        .jab_active (jab_active),
        .jab_start  (jab_start)
    );

    assign jab_state = fsm_state;

endmodule

// File: rtl/jab_watchdog_chk.sv
module jab_watchdog_chk #(
    parameter int JAB_TICKS   = 105000,
    parameter int UNJAB_TICKS = 406000,
    localparam int ACW = jab_pkg::cnt_width(JAB_TICKS),
    localparam int RCW = jab_pkg::cnt_width(UNJAB_TICKS)
) (
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic           tx_req,
    input logic           tx_en,
    input logic           jab_active,
    input logic           jab_start,
    input logic [1:0]     jab_state,
    input logic [ACW-1:0] act_cnt,
    input logic [RCW-1:0] rec_cnt
);

    localparam logic [1:0] S_RUN = 2'b00;
    localparam logic [1:0] S_HLD = 2'b01;
    localparam logic [1:0] S_REC = 2'b10;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (jab_state == S_RUN && !jab_active && !jab_start)); // R1

    AST_RUN_PASS: assert property (@(posedge clk) disable iff (rst)
        (jab_state == S_RUN) |-> (tx_en == tx_req)); // R2

    AST_ENTRY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (jab_state == S_HLD && $past(jab_state) == S_RUN) |-> $past(tick && tx_req)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(act_cnt) < JAB_TICKS)); // R4

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        jab_start |=> !jab_start); // R5

    AST_START_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        jab_start |-> (jab_state == S_HLD && $past(jab_state) == S_RUN)); // R5

    AST_LOCK_GATE: assert property (@(posedge clk) disable iff (rst)
        (jab_state != S_RUN) |-> (!tx_en && jab_active)); // R6

    AST_HELD_EXIT: assert property (@(posedge clk) disable iff (rst)
        (jab_state == S_HLD && !tx_req) |=> (jab_state == S_REC)); // R7

    AST_REC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(rec_cnt) < UNJAB_TICKS)); // R8

    AST_RECOVER_REARM: assert property (@(posedge clk) disable iff (rst)
        (jab_state == S_REC && tx_req) |=> (jab_state == S_HLD)); // R9

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && jab_state != S_HLD) |=> $stable(jab_state) || (jab_state == S_HLD)); // R10

endmodule

bind jab_watchdog jab_watchdog_chk #(
    .JAB_TICKS   (JAB_TICKS),
    .UNJAB_TICKS (UNJAB_TICKS)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .tx_req     (tx_req),
    .tx_en      (tx_en),
    .jab_active (jab_active),
    .jab_start  (jab_start),
    .jab_state  (jab_state),
    .act_cnt    (act_cnt),
    .rec_cnt    (rec_cnt)
);

// File: tb/jab_watchdog_tb_top.sv
module jab_watchdog_tb_top;

    localparam int JAB   = 5;
    localparam int UNJAB = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       tx_req = 1'b0;
    logic       tx_en;
    logic       jab_active;
    logic       jab_start;
    logic [1:0] jab_state;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    jab_watchdog #(.JAB_TICKS(JAB), .UNJAB_TICKS(UNJAB)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .tx_req     (tx_req),
        .tx_en      (tx_en),
        .jab_active (jab_active),
        .jab_start  (jab_start),
        .jab_state  (jab_state)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, then look just after the next rising edge
    task automatic step(input bit req, input bit tk);
        @(negedge clk);
        tx_req = req;
        tick   = tk;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step(1'b1, 1'b1);
        chk("R1", "state", int'(jab_state), 0);
        chk("R1", "jab_active", int'(jab_active), 0);
        chk("R1", "jab_start", int'(jab_start), 0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b0);
    endtask

    task automatic t_pass();
        step(1'b1, 1'b0);
        chk("R2", "tx_en req high", int'(tx_en), 1);
        step(1'b0, 1'b0);
        chk("R2", "tx_en req low", int'(tx_en), 0);
    endtask

    task automatic t_entry();
        for (int i = 0; i < JAB - 1; i++) begin
            step(1'b1, 1'b1);
            chk("R3", "state before limit", int'(jab_state), 0);
        end
        step(1'b1, 1'b1);
        chk("R3", "state at limit", int'(jab_state), 1);
        chk("R3", "jab_active", int'(jab_active), 1);
        chk("R3", "tx_en", int'(tx_en), 0);
        chk("R5", "jab_start first cycle", int'(jab_start), 1);
        step(1'b1, 1'b0);
        chk("R5", "jab_start second cycle", int'(jab_start), 0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
        chk("R6", "state held", int'(jab_state), 1);
        chk("R6", "tx_en held", int'(tx_en), 0);
    endtask

    task automatic t_recover();
        step(1'b0, 1'b1);
        chk("R7", "state after drop", int'(jab_state), 2);
        chk("R6", "tx_en recover", int'(tx_en), 0);
        for (int i = 0; i < UNJAB - 1; i++) begin
            step(1'b0, 1'b0);
            step(1'b0, 1'b1);
        end
        chk("R8", "state before limit", int'(jab_state), 2);
        step(1'b0, 1'b1);
        chk("R8", "state at limit", int'(jab_state), 0);
        chk("R8", "jab_active cleared", int'(jab_active), 0);
        step(1'b1, 1'b0);
        chk("R8", "tx_en restored", int'(tx_en), 1);
        step(1'b0, 1'b0);
    endtask

    task automatic t_restart();
        for (int i = 0; i < JAB; i++) step(1'b1, 1'b1);
        chk("R3", "state re-entry", int'(jab_state), 1);
        step(1'b0, 1'b1);
        for (int i = 0; i < UNJAB - 2; i++) step(1'b0, 1'b1);
        chk("R9", "state mid recovery", int'(jab_state), 2);
        step(1'b1, 1'b0);
        chk("R9", "state back to held", int'(jab_state), 1);
        chk("R5", "no pulse from recover", int'(jab_start), 0);
        step(1'b0, 1'b1);
        chk("R9", "state recover again", int'(jab_state), 2);
        for (int i = 0; i < UNJAB - 1; i++) step(1'b0, 1'b1);
        chk("R9", "full interval needed", int'(jab_state), 2);
        step(1'b0, 1'b1);
        chk("R9", "exit after full interval", int'(jab_state), 0);
    endtask

    task automatic t_clear();
        for (int i = 0; i < JAB - 1; i++) step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        chk("R4", "state after gap", int'(jab_state), 0);
        for (int i = 0; i < JAB - 1; i++) step(1'b1, 1'b1);
        chk("R4", "state after second burst", int'(jab_state), 0);
        chk("R4", "tx_en second burst", int'(tx_en), 1);
        step(1'b1, 1'b1);
        chk("R4", "state at full count", int'(jab_state), 1);
        step(1'b0, 1'b0);
        for (int i = 0; i < UNJAB; i++) step(1'b0, 1'b1);
        chk("R8", "state recovered", int'(jab_state), 0);
    endtask

    task automatic t_tickgate();
        for (int i = 0; i < 3 * JAB; i++) step(1'b1, 1'b0);
        chk("R10", "state without ticks", int'(jab_state), 0);
        chk("R10", "tx_en without ticks", int'(tx_en), 1);
        step(1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_entry();
        t_recover();
        t_restart();
        t_clear();
        t_tickgate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule